// File: doc/BRIEF.md
# Cyclic Line-to-Strip Divider

This block takes an unbroken raster of 12-bit grayscale pixels, at most one per clock, and deals each image line out to three downstream compression lanes. Every line is cut into three fixed-width vertical segments. The first segment goes to lane 0, the second to lane 1 and the third to lane 2. The next line starts again at lane 0. Each lane therefore receives an endless strip of constant width. There is no frame boundary, because the image has no length limit.

The input is a valid/data pair plus a start-of-line marker. The block applies no backpressure and accepts a pixel on every cycle that valid is high. Each lane output carries a valid, the pixel and an end-of-segment marker. A line start that arrives before the current line is complete sets a sticky error flag. The block then restarts the line count from that pixel.

Control is a two-state machine. After reset it is in HUNT, where pixels are discarded. The transition SYNC, taken on the first valid pixel that carries the line-start marker, moves it to RUN. It stays in RUN until reset. In RUN, a segment counter and a lane index step through the line. Two events act inside RUN. SEG_END is the last pixel of a segment: it advances the lane and wraps after the last lane. RESYNC is an early line start: it sets the error flag and forces lane 0 at count 0.

Top module: `strip_divider`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, all lane valids, all end-of-segment markers and `sync_err` are 0.
- R2: A pixel accepted at a clock edge appears on exactly one lane, with its data unchanged, in the cycle right after that edge. No lane is valid in a cycle that did not follow an accepted pixel.
- R3: Lane k receives LINE_W/LANES pixels of each line, plus one more when k < LINE_W mod LANES. With the defaults the widths are 1667, 1667 and 1666. Within a line the segments go to lane 0, then lane 1, then lane 2.
- R4: `lane_eol[k]` is 1 together with `lane_valid[k]` on the last pixel of lane k's segment, and is 0 on every other pixel.
- R5: After LINE_W pixels the next pixel starts a new line on lane 0, whether or not it carries the line-start marker. No frame end exists.
- R6: A cycle with `in_valid` low produces no lane output and does not advance the line position.
- R7: After reset, valid pixels are discarded until the first valid pixel with `in_sol` = 1. That pixel is the first pixel of a line.
- R8: A valid pixel with `in_sol` = 1 at a line position other than 0 sets `sync_err`. The flag stays set until reset. The pixel is routed as the first pixel of a new line, to lane 0 without an end marker.
- R9: A valid pixel with `in_sol` = 1 at line position 0 leaves `sync_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is present this cycle |
| in_sol | input | 1 | Input pixel is the first of a line (qualified by in_valid) |
| in_data | input | PIX_W | Grayscale pixel value |
| lane_valid | output | LANES | Per-lane pixel valid, bit k for lane k |
| lane_eol | output | LANES | Per-lane end-of-segment marker |
| lane_data | output | LANES*PIX_W | Per-lane pixel; lane k in bits [k*PIX_W +: PIX_W] |
| sync_err | output | 1 | Sticky flag for a line start that arrived too early |

## Verification
The sharpest collision is a RESYNC that lands on the cycle where SEG_END would otherwise fire. That pixel is the last one of a segment, and it carries an early line start. The bench provokes this by raising `in_sol` on line position 1666, the final pixel of lane 0's segment. A behavioural model, which tracks only the position within the line, judges the result: the pixel must appear on lane 0 with no end marker, the error flag must rise, and lane 0 must then take a full segment of 1667 pixels again. A second early start in the middle of lane 2 shows that the flag stays set.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

    // width of segment k when a line of line_w pixels is shared by lanes lanes
    function automatic int seg_len(int line_w, int lanes, int k);
        return line_w / lanes + ((k < (line_w % lanes)) ? 1 : 0);
    endfunction

endpackage

// File: rtl/sd_seg_tracker.sv
module sd_seg_tracker
    import sd_pkg::*;
#(
    parameter int LINE_W = 5000,
    parameter int LANES  = 3,
    parameter int LIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              restart,
    output logic [LIDX_W-1:0] cur_lane,
    output logic              seg_last,
    output logic              line_start
);
    localparam int CNT_W = $clog2(LINE_W / LANES + 2);

    logic [LIDX_W-1:0] lane_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_now;

    always_comb begin
        cur_lane   = restart ? '0 : lane_q;
        cnt_now    = restart ? '0 : cnt_q;
        seg_last   = (cnt_now == CNT_W'(seg_len(LINE_W, LANES, int'(cur_lane)) - 1));
        line_start = (lane_q == '0) && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            cnt_q  <= '0;
        end else if (adv) begin
            if (seg_last) begin
                cnt_q  <= '0;
                lane_q <= (cur_lane == LIDX_W'(LANES - 1)) ? '0 : cur_lane + 1'b1;
            end else begin
                cnt_q  <= cnt_now + 1'b1;
                lane_q <= cur_lane;
            end
        end
    end
endmodule

// File: rtl/sd_lane_out.sv
module sd_lane_out #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             last,
    input  logic [PIX_W-1:0] din,
    output logic             valid,
    output logic             eol,
    output logic [PIX_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            eol   <= 1'b0;
            dout  <= '0;
        end else begin
            valid <= hit;
            eol   <= hit && last;
            if (hit) dout <= din;
        end
    end
endmodule

// File: rtl/strip_divider.sv
module strip_divider
    import sd_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 5000,
    parameter int LANES  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sol,
    input  logic [PIX_W-1:0]       in_data,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES-1:0]       lane_eol,
    output logic [LANES*PIX_W-1:0] lane_data,
    output logic                   sync_err
);
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    state_t            state_q, state_d;
    logic              accept, restart, early, err_q;
    logic [LIDX_W-1:0] cur_lane;
    logic              seg_last, line_start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (early) err_q <= 1'b1;
        end
    end

    // next state and control
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        early   = 1'b0;
        restart = in_valid && in_sol;
        unique case (state_q)
            ST_HUNT: begin
                if (restart) begin         // SYNC
                    state_d = ST_RUN;
                    accept  = 1'b1;
                end
            end
            ST_RUN: begin
                accept = in_valid;
                early  = restart && !line_start;  // RESYNC
            end
            default: state_d = ST_HUNT;
        endcase
    end

    assign sync_err = err_q;

    sd_seg_tracker #(
        .LINE_W (LINE_W),
        .LANES  (LANES),
        .LIDX_W (LIDX_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (accept),
        .restart    (restart),
        .cur_lane   (cur_lane),
        .seg_last   (seg_last),
        .line_start (line_start)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sd_lane_out #(.PIX_W(PIX_W)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (accept && (cur_lane == LIDX_W'(k))),
            .last  (seg_last),
            .din   (in_data),
            .valid (lane_valid[k]),
            .eol   (lane_eol[k]),
            .dout  (lane_data[k*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/strip_divider_chk.sv
module strip_divider_chk
    import sd_pkg::*;
#(
    parameter int LINE_W = 5000,
    parameter int LANES  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sol,
    input logic [LANES-1:0] lane_valid,
    input logic [LANES-1:0] lane_eol,
    input logic             sync_err,
    input logic             hunting
);
    p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_valid));

    p_out_follows_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_valid) |-> $past(in_valid));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> $past(in_valid && in_sol));

    p_hunt_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && !(in_valid && in_sol)) |=> (lane_valid == '0));

    for (genvar k = 0; k < LANES; k++) begin : g_w
        int cnt;
        always_ff @(posedge clk) begin
            if (!rst_n || (in_valid && in_sol)) cnt <= 0;
            else if (lane_valid[k]) cnt <= lane_eol[k] ? 0 : cnt + 1;
        end
        p_seg_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_valid[k] && lane_eol[k]) |-> (cnt == seg_len(LINE_W, LANES, k) - 1));
    end
endmodule

bind strip_divider strip_divider_chk #(
    .LINE_W (LINE_W),
    .LANES  (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .lane_valid (lane_valid),
    .lane_eol   (lane_eol),
    .sync_err   (sync_err),
    .hunting    (state_q == sd_pkg::ST_HUNT)
);

// File: tb/sim_strip_divider.sv
module sim_strip_divider;
    localparam int CLK_T  = 10;
    localparam int PIX_W  = 12;
    localparam int LINE_W = 5000;
    localparam int LANES  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sol = 1'b0;
    logic [PIX_W-1:0] in_data = '0;
    logic [LANES-1:0] lane_valid, lane_eol;
    logic [LANES*PIX_W-1:0] lane_data;
    logic sync_err;

    int total = 0, bad = 0;
    bit done = 0;

    int pos = -1;            // line position, -1 while waiting for a line start
    bit eerr = 0;
    logic [LANES-1:0] ev, ee;
    logic [PIX_W-1:0] ed;
    int obs [LANES];

    strip_divider #(.PIX_W(PIX_W), .LINE_W(LINE_W), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_data(in_data), .lane_valid(lane_valid), .lane_eol(lane_eol),
        .lane_data(lane_data), .sync_err(sync_err)
    );

    always #(CLK_T/2) clk = ~clk;

    function automatic int width_of(int k);
        return LINE_W / LANES + ((k < LINE_W % LANES) ? 1 : 0);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input bit s, input logic [PIX_W-1:0] d);
        in_valid = v; in_sol = s; in_data = d;
        ev = '0; ee = '0; ed = d;
        if (v) begin
            if (pos < 0) begin
                if (s) pos = 0;
            end else if (s && pos != 0) begin
                eerr = 1; pos = 0;
            end
            if (pos >= 0) begin
                int acc = 0;
                for (int k = 0; k < LANES; k++) begin
                    if (pos >= acc && pos < acc + width_of(k)) begin
                        ev[k] = 1'b1;
                        ee[k] = (pos == acc + width_of(k) - 1);
                    end
                    acc += width_of(k);
                end
                pos = (pos + 1) % LINE_W;
            end
        end
        @(posedge clk); #1;
        for (int k = 0; k < LANES; k++) begin
            check(lane_valid[k] === ev[k], "R2", $sformatf("valid lane %0d", k), lane_valid[k], ev[k]);
            if (ev[k]) begin
                check(lane_data[k*PIX_W +: PIX_W] === ed, "R2", "data",
                      lane_data[k*PIX_W +: PIX_W], ed);
                check(lane_eol[k] === ee[k], "R4", $sformatf("eol lane %0d", k), lane_eol[k], ee[k]);
            end
            if (lane_valid[k]) obs[k]++;
        end
        check(sync_err === eerr, "R8", "sync_err", sync_err, eerr);
        @(negedge clk);
    endtask

    task automatic run_pixels(int n, int gap_every, int seed);
        for (int i = 0; i < n; i++) begin
            if (gap_every > 0 && i % gap_every == 0) cyc(1'b0, 1'b0, '0);   // R6 idle cycle
            cyc(1'b1, 1'b0, PIX_W'(i * 37 + seed));
        end
    endtask

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < LANES; k++) obs[k] = 0;
        repeat (3) @(negedge clk);
        check(lane_valid === '0 && lane_eol === '0 && sync_err === 1'b0, "R1", "reset outputs", lane_valid, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(lane_valid === '0 && sync_err === 1'b0, "R1", "after release", lane_valid, 0);
        @(negedge clk);

        // R7: pixels before the first line start are dropped
        run_pixels(6, 0, 11);
        check(obs[0] + obs[1] + obs[2] == 0, "R7", "dropped pixels", obs[0] + obs[1] + obs[2], 0);

        // R3: one clean line, widths per lane
        cyc(1'b1, 1'b1, 12'h5a5);
        run_pixels(LINE_W - 1, 0, 3);
        for (int k = 0; k < LANES; k++) begin
            check(obs[k] == width_of(k), "R3", $sformatf("pixels on lane %0d", k), obs[k], width_of(k));
            obs[k] = 0;
        end

        // R5 and R6: next line with no marker, idle gaps sprinkled in
        run_pixels(LINE_W, 7, 9);
        check(obs[0] == width_of(0), "R5", "lane 0 after wrap", obs[0], width_of(0));

        // R9: marker exactly at line position 0 leaves the flag clear
        cyc(1'b1, 1'b1, 12'h0f0);
        check(sync_err === 1'b0, "R9", "on-time line start", sync_err, 0);
        run_pixels(width_of(0) - 2, 0, 21);

        // R8: early line start on the last pixel of lane 0's segment
        cyc(1'b1, 1'b1, 12'habc);
        check(sync_err === 1'b1, "R8", "early start sets flag", sync_err, 1);
        run_pixels(LINE_W - 1, 5, 4);

        // R8: second early start in the middle of lane 2, flag remains
        run_pixels(4000, 0, 17);
        cyc(1'b1, 1'b1, 12'h123);
        run_pixels(LINE_W + 20, 0, 2);
        cyc(1'b0, 1'b0, '0);
        check(sync_err === 1'b1, "R8", "flag sticky", sync_err, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule